// File: doc/BRIEF.md
# Code Block CRC Attach and Lifting-Size Packer

This block sits in front of an LDPC encoder. It takes one code block of message bits as 32-bit stream words. When enabled, it appends a 24-bit block CRC. It then fills the block up to its full information length with zero filler bits. The result leaves as columns of one lifting size each. Every column occupies a fixed slot of twelve 32-bit output words. The first Zc bits of the slot carry data, and every bit past Zc is zero. An encoder downstream can therefore treat each slot as one aligned Zc-bit column, for any Zc up to 384.

Before each block, a single-cycle write loads a 35-bit configuration word while the block is idle. The word holds the lifting size, the base graph, the CRC enable, the information length Kp and the filler count. The block then raises its sink ready and consumes exactly the message length. It packs bits through a 64-bit bit reservoir and streams slots out until the last column has gone.

Both stream sides use valid/ready. A word transfers on a rising edge where valid and ready are both high. The sink side is stalled by `s_ready`, which is combinational from internal state only and never depends on `s_valid`. `s_ready` is low while the block is idle and after the last message word, and it also drops whenever the reservoir holds more than one word. The source side holds `m_data`, `m_sop` and `m_eop` steady for as long as `m_valid` is high and `m_ready` is low.

Top module: `cb_crc_packer`

## Requirements
- R1: While idle, a cycle with `cfg_we` high captures `cfg_word`, whose fields sit at these positions: filler count [34:25], Kp [24:11], Zc [10:2], base graph [1], CRC enable [0]. `s_ready` is high in the cycle after the capture.
- R2: Bit 0 of each word is the earliest bit in sequence on both sides, and the message bits appear first in the output bit sequence, in order.
- R3: With CRC enabled, the sink takes Kp−24 message bits. Directly after them come 24 CRC bits, computed with polynomial x^24+x^23+x^6+x^5+x+1 and a zero initial value, most significant CRC bit first. With CRC disabled, the sink takes Kp message bits.
- R4: After the Kp information bits, the bit sequence continues with zero filler bits up to K = 22·Zc (base graph 0) or K = 10·Zc (base graph 1).
- R5: Each group of 12 output words carries the next Zc bits of the sequence from the bit 0 of its first word upward. Every output bit at a position of Zc or more within its group is zero.
- R6: A block emits 22 groups with base graph 0 and 10 groups with base graph 1. `m_sop` marks only the first word and `m_eop` marks only the last word.
- R7: In the final sink word, bits above the remaining message count are ignored.
- R8: `s_ready` is low while idle and after the last message word has been taken.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_eop` hold their values.
- R10: A `cfg_we` pulse while a block is in progress is ignored, and the block completes unchanged.
- R11: The reset `rst_n` is asynchronous and active low, and may be held for 10 or more cycles. It clears `m_valid` and `s_ready` at once and abandons any block in progress. The next configuration write starts a clean block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 35 | Configuration word (fields per R1) |
| s_data | input | 32 | Message bits, bit 0 earliest |
| s_valid | input | 1 | Sink word valid |
| s_sop | input | 1 | Sink first word of block |
| s_eop | input | 1 | Sink last word of block |
| s_ready | output | 1 | Sink may transfer on this edge |
| m_ready | input | 1 | Downstream accepts on this edge |
| m_data | output | 32 | Packed column word, bit 0 earliest |
| m_valid | output | 1 | Output word valid |
| m_sop | output | 1 | First word of block |
| m_eop | output | 1 | Last word of block |

## Verification
A configuration write taken at one edge shows up as `s_ready` high one cycle later. A sink word taken at edge N can feed an output word that becomes visible after edge N+1 at the earliest, because the only registers on that path are the reservoir and the output stage. A stalled output word must still be present one edge later. The bench drives on the falling edge and samples one time step after it. It records a transfer only in the half-cycle where both valid and ready are high, so it compares output words by their sequence position rather than by a fixed latency. This keeps the data, marker and stall checks correct under the bench's irregular `s_valid` gaps and `m_ready` stalls.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  localparam int DW         = 32;
  localparam int SLOT_WORDS = 12;
  localparam int CRC_W      = 24;
  localparam int GROUPS_BG0 = 22;
  localparam int GROUPS_BG1 = 10;
  localparam int NULL_W     = 10;
  localparam int KP_W       = 14;
  localparam int ZC_W       = 9;
  localparam int GRP_W      = 5;

  // field order fixes bit positions: [34:25] [24:11] [10:2] [1] [0]
  typedef struct packed {
    logic [NULL_W-1:0] null_cnt;
    logic [KP_W-1:0]   kp;
    logic [ZC_W-1:0]   zc;
    logic              bg;
    logic              crc_en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {PH_IDLE, PH_MSG, PH_CRC, PH_FILL} phase_e;
endpackage

// File: rtl/cbp_crc24.sv
module cbp_crc24 #(
  parameter int DW = 32,
  parameter int CW = 24,
  parameter logic [CW-1:0] POLY = 24'h800063,
  localparam int NW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [DW-1:0] din,
  input  logic [NW-1:0] nbits,
  output logic [CW-1:0] crc
);
  logic [CW-1:0] nxt;

  // serial division unrolled over the word, earliest bit first
  always_comb begin
    nxt = crc;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(nbits)) begin
        if (din[i] ^ nxt[CW-1]) nxt = {nxt[CW-2:0], 1'b0} ^ POLY;
        else                    nxt = {nxt[CW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (upd) crc <= nxt;
  end
endmodule

// File: rtl/cbp_bitbuf.sv
module cbp_bitbuf #(
  parameter int DW = 32,
  localparam int BW = 2 * DW,
  localparam int NW = $clog2(DW + 1),
  localparam int LW = $clog2(BW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [NW-1:0] push_n,
  input  logic [NW-1:0] pop_n,
  output logic [LW-1:0] level,
  output logic [DW-1:0] head
);
  logic [BW-1:0] store_q, store_d;
  logic [LW-1:0] level_d, base;
  logic [DW-1:0] pmask, pdata;

  always_comb begin
    for (int i = 0; i < DW; i++) pmask[i] = (i < int'(push_n));
    pdata   = push ? (push_data & pmask) : '0;
    base    = level - LW'(pop_n);
    store_d = (store_q >> pop_n) | ({{DW{1'b0}}, pdata} << base);
    level_d = base + (push ? LW'(push_n) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      level   <= '0;
    end else if (clr) begin
      store_q <= '0;
      level   <= '0;
    end else begin
      store_q <= store_d;
      level   <= level_d;
    end
  end

  assign head = store_q[DW-1:0];

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    LW'(pop_n) <= level); // R5
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> level <= LW'(DW)); // R7
endmodule

// File: rtl/cbp_slot_seq.sv
module cbp_slot_seq #(
  parameter int DW         = 32,
  parameter int SLOT_WORDS = 12,
  parameter int ZC_W       = 9,
  parameter int GRP_W      = 5,
  localparam int NW = $clog2(DW + 1),
  localparam int LW = $clog2(2 * DW + 1),
  localparam int SW = $clog2(SLOT_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic [ZC_W-1:0]  zc,
  input  logic [GRP_W-1:0] groups,
  input  logic [LW-1:0]    level,
  input  logic [DW-1:0]    head,
  input  logic             m_ready,
  output logic [NW-1:0]    pop_n,
  output logic             fire,
  output logic             last_fire,
  output logic [DW-1:0]    m_data,
  output logic             m_valid,
  output logic             m_sop,
  output logic             m_eop
);
  logic [SW-1:0]    slot;
  logic [GRP_W-1:0] grp;
  logic [NW-1:0]    need;
  logic [DW-1:0]    wmask;
  int               offs, rem;

  // bits of this slot still inside the lifting size
  always_comb begin
    offs = int'(slot) * DW;
    rem  = int'(zc) - offs;
    if (rem <= 0)      need = '0;
    else if (rem >= DW) need = NW'(DW);
    else               need = NW'(rem);
    for (int i = 0; i < DW; i++) wmask[i] = (i < int'(need));
  end

  assign fire      = active && (!m_valid || m_ready) && (level >= LW'(need));
  assign last_fire = fire && (slot == SW'(SLOT_WORDS - 1)) && (grp == groups - GRP_W'(1));
  assign pop_n     = fire ? need : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= '0;
      grp     <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_sop   <= 1'b0;
      m_eop   <= 1'b0;
    end else begin
      if (clr) begin
        slot <= '0;
        grp  <= '0;
      end else if (fire) begin
        if (slot == SW'(SLOT_WORDS - 1)) begin
          slot <= '0;
          grp  <= grp + GRP_W'(1);
        end else begin
          slot <= slot + SW'(1);
        end
      end
      if (fire) begin
        m_valid <= 1'b1;
        m_data  <= head & wmask;
        m_sop   <= (slot == '0) && (grp == '0);
        m_eop   <= last_fire;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_eop))); // R9
  AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !(m_sop && m_eop)); // R6
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot) < SLOT_WORDS); // R5
endmodule

// File: rtl/cb_crc_packer.sv
module cb_crc_packer
  import cbp_pkg::*;
#(
  parameter int DW         = cbp_pkg::DW,
  parameter int SLOT_WORDS = cbp_pkg::SLOT_WORDS,
  parameter int CRC_W      = cbp_pkg::CRC_W,
  parameter logic [CRC_W-1:0] CRC_POLY = 24'h800063
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [DW-1:0]    s_data,
  input  logic             s_valid,
  input  logic             s_sop,
  input  logic             s_eop,
  output logic             s_ready,
  input  logic             m_ready,
  output logic [DW-1:0]    m_data,
  output logic             m_valid,
  output logic             m_sop,
  output logic             m_eop
);
  localparam int NW = $clog2(DW + 1);
  localparam int LW = $clog2(2 * DW + 1);

  phase_e           phase;
  cfg_t             cfg_in, cfg_q;
  logic [KP_W-1:0]  msg_left, msg_full;
  logic [LW-1:0]    level;
  logic [DW-1:0]    head, push_data;
  logic [NW-1:0]    push_n, pop_n, take_n;
  logic             push, start, accept, fire, last_fire, room, active;
  logic [CRC_W-1:0] crc, crc_rev;
  logic [GRP_W-1:0] groups;

  assign cfg_in   = cfg_t'(cfg_word);
  assign start    = cfg_we && (phase == PH_IDLE);
  assign msg_full = cfg_in.kp - (cfg_in.crc_en ? KP_W'(CRC_W) : '0);
  assign room     = level <= LW'(DW);
  assign s_ready  = (phase == PH_MSG) && (msg_left != '0) && room;
  assign accept   = s_valid && s_ready;
  assign take_n   = (msg_left >= KP_W'(DW)) ? NW'(DW) : NW'(msg_left);
  assign groups   = cfg_q.bg ? GRP_W'(GROUPS_BG1) : GRP_W'(GROUPS_BG0);
  assign active   = phase != PH_IDLE;

  always_comb begin
    for (int i = 0; i < CRC_W; i++) crc_rev[i] = crc[CRC_W-1-i];
  end

  always_comb begin
    push      = 1'b0;
    push_data = '0;
    push_n    = '0;
    unique case (phase)
      PH_MSG: if (accept) begin
        push = 1'b1; push_data = s_data; push_n = take_n;
      end
      PH_CRC: if (room) begin
        push = 1'b1; push_data = DW'(crc_rev); push_n = NW'(CRC_W);
      end
      PH_FILL: if (room) begin
        push = 1'b1; push_n = NW'(DW);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cfg_q    <= '0;
      msg_left <= '0;
    end else if (start) begin
      cfg_q    <= cfg_in;
      msg_left <= msg_full;
      phase    <= PH_MSG;
    end else if (last_fire) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_MSG: begin
          if (msg_left == '0) begin
            phase <= cfg_q.crc_en ? PH_CRC : PH_FILL;
          end else if (accept) begin
            msg_left <= msg_left - KP_W'(take_n);
            if (msg_left == KP_W'(take_n)) phase <= cfg_q.crc_en ? PH_CRC : PH_FILL;
          end
        end
        PH_CRC:  if (room) phase <= PH_FILL;
        default: ;
      endcase
    end
  end

  cbp_crc24 #(.DW(DW), .CW(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start), .upd(accept),
    .din(s_data), .nbits(take_n), .crc(crc)
  );

  cbp_bitbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(start), .push(push), .push_data(push_data),
    .push_n(push_n), .pop_n(pop_n), .level(level), .head(head)
  );

  cbp_slot_seq #(.DW(DW), .SLOT_WORDS(SLOT_WORDS), .ZC_W(ZC_W), .GRP_W(GRP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(start), .active(active), .zc(cfg_q.zc),
    .groups(groups), .level(level), .head(head), .m_ready(m_ready),
    .pop_n(pop_n), .fire(fire), .last_fire(last_fire), .m_data(m_data),
    .m_valid(m_valid), .m_sop(m_sop), .m_eop(m_eop)
  );

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && cfg_we) |=> $stable(cfg_q)); // R10
  AST_SOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && s_sop) |-> (msg_left == cfg_q.kp - (cfg_q.crc_en ? KP_W'(CRC_W) : '0))); // R2
  AST_EOP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && s_eop) |-> (msg_left <= KP_W'(DW))); // R7
  AST_CRC_AFTER_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CRC) |-> (msg_left == '0)); // R3
  AST_CFG_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (int'(cfg_in.kp) + int'(cfg_in.null_cnt) ==
               (cfg_in.bg ? GROUPS_BG1 : GROUPS_BG0) * int'(cfg_in.zc))); // R4
  AST_IDLE_NO_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !s_ready); // R8
endmodule

// File: tb/cb_crc_packer_tb.sv
module cb_crc_packer_tb;
  import cbp_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_word = '0;
  logic [31:0]      s_data = '0;
  logic             s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0;
  logic             s_ready;
  logic             m_ready = 1'b0;
  logic [31:0]      m_data;
  logic             m_valid, m_sop, m_eop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cb_crc_packer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .s_data(s_data), .s_valid(s_valid), .s_sop(s_sop), .s_eop(s_eop),
    .s_ready(s_ready), .m_ready(m_ready), .m_data(m_data),
    .m_valid(m_valid), .m_sop(m_sop), .m_eop(m_eop)
  );

  // {bg, zc[8:0], crc_en, kp[13:0], seed[7:0]}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 9'd40, 1'b1, 14'd800,  8'h3a},
    {1'b1, 9'd40, 1'b0, 14'd400,  8'h51},
    {1'b1, 9'd16, 1'b1, 14'd100,  8'h07},
    {1'b0, 9'd64, 1'b1, 14'd1000, 8'hc4},
    {1'b1, 9'd33, 1'b0, 14'd301,  8'h9d},
    {1'b0, 9'd32, 1'b1, 14'd704,  8'h22}
  };

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit msg_bit(int pos, int seed);
    logic [31:0] h;
    h = (32'(pos) * 32'h9E3779B1) ^ (32'(seed) * 32'h85EBCA6B);
    h = h ^ (h >> 15);
    return h[7];
  endfunction

  task automatic write_cfg(int bg, int zc, int crc_en, int kp);
    int k;
    k = (bg != 0 ? 10 : 22) * zc;
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_word = {10'(k - kp), 14'(kp), 9'(zc), 1'(bg), 1'(crc_en)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(int idx, bit inject);
    int bg, zc, crc_en, kp, seed, groups, mlen, nwords, nexp;
    logic [23:0] crc;
    int e_msg, e_crc, e_fill, e_pad, got, bad_mark, stall_err;
    bit eop_seen;
    bg = int'(VEC[idx][32]); zc = int'(VEC[idx][31:23]); crc_en = int'(VEC[idx][22]);
    kp = int'(VEC[idx][21:8]); seed = int'(VEC[idx][7:0]);
    groups = (bg != 0) ? 10 : 22;
    mlen   = (crc_en != 0) ? kp - 24 : kp;
    nwords = (mlen + 31) / 32;
    nexp   = groups * 12;
    crc = '0;
    for (int p = 0; p < mlen; p++) begin
      if (msg_bit(p, seed) ^ crc[23]) crc = {crc[22:0], 1'b0} ^ 24'h800063;
      else                            crc = {crc[22:0], 1'b0};
    end
    e_msg = 0; e_crc = 0; e_fill = 0; e_pad = 0; got = 0; bad_mark = 0; stall_err = 0;
    eop_seen = 1'b0;
    write_cfg(bg, zc, crc_en, kp);
    #1 check(s_ready === 1'b1, "R1", "s_ready after cfg write", int'(s_ready), 1);
    fork
      begin : drive
        int w = 0, cyc = 0;
        bit inj_done = 1'b0;
        while (w < nwords) begin
          @(negedge clk);
          cfg_we = 1'b0;
          if (inject && !inj_done && w == 2) begin
            cfg_we   = 1'b1;
            cfg_word = {10'd0, 14'd160, 9'd16, 1'b1, 1'b0};
            inj_done = 1'b1;
          end
          s_valid = ((cyc * 7 + idx) % 5) != 0;
          cyc++;
          for (int b = 0; b < 32; b++) begin
            int p = w * 32 + b;
            s_data[b] = (p < mlen) ? msg_bit(p, seed) : 1'b1;
          end
          s_sop = (w == 0);
          s_eop = (w == nwords - 1);
          #1;
          if (s_valid && s_ready) w++;
        end
        @(negedge clk);
        cfg_we = 1'b0; s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
      end
      begin : watch
        int cyc = 0;
        bit held = 1'b0;
        logic [31:0] hd = '0;
        while (!eop_seen && cyc < 30000) begin
          @(negedge clk);
          m_ready = ((cyc * 3 + idx) % 7) != 0;
          cyc++;
          #1;
          if (held && !(m_valid === 1'b1 && m_data === hd)) stall_err++;
          held = 1'b0;
          if (m_valid && m_ready) begin
            int g = got / 12, s = got % 12;
            for (int b = 0; b < 32; b++) begin
              int inpos = s * 32 + b;
              int pos = g * zc + inpos;
              bit eb;
              if (inpos >= zc) begin
                if (m_data[b] !== 1'b0) e_pad++;
              end else if (pos < mlen) begin
                eb = msg_bit(pos, seed);
                if (m_data[b] !== eb) e_msg++;
              end else if (crc_en != 0 && pos < mlen + 24) begin
                eb = crc[23 - (pos - mlen)];
                if (m_data[b] !== eb) e_crc++;
              end else begin
                if (m_data[b] !== 1'b0) e_fill++;
              end
            end
            if (m_sop !== (got == 0)) bad_mark++;
            if (m_eop !== (got == nexp - 1)) bad_mark++;
            if (m_eop) eop_seen = 1'b1;
            got++;
          end else if (m_valid) begin
            held = 1'b1;
            hd = m_data;
          end
        end
      end
    join
    check(e_msg == 0, "R2", "message bit mismatches (R7 tail masking)", e_msg, 0);
    if (crc_en != 0) check(e_crc == 0, "R3", "CRC bit mismatches", e_crc, 0);
    check(e_fill == 0, "R4", "nonzero filler bits", e_fill, 0);
    check(e_pad == 0, "R5", "nonzero pad bits above Zc", e_pad, 0);
    check(got == nexp, "R6", "output word count", got, nexp);
    check(bad_mark == 0, "R6", "misplaced sop/eop markers", bad_mark, 0);
    check(stall_err == 0, "R9", "words changed under stall", stall_err, 0);
    @(negedge clk); #1;
    check(s_ready === 1'b0, "R8", "s_ready after block end", int'(s_ready), 0);
    if (inject)
      check(e_msg + e_crc + e_fill + e_pad == 0 && got == nexp, "R10",
            "block disturbed by mid-block cfg write", e_msg + e_crc + e_fill + e_pad, 0);
  endtask

  initial begin
    repeat (12) @(negedge clk);
    #1;
    check(m_valid === 1'b0, "R11", "m_valid held in reset", int'(m_valid), 0);
    check(s_ready === 1'b0, "R8", "s_ready while idle after reset", int'(s_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) run_case(i, i == 3);

    // reset in the middle of a block, then a clean block (R11)
    write_cfg(0, 40, 1, 800);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sop = (w == 0); s_eop = 1'b0; s_data = 32'hA5A5_0000 + 32'(w);
    end
    m_ready = 1'b0;
    repeat (4) @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0;
    rst_n = 1'b0;
    #1;
    check(m_valid === 1'b0, "R11", "m_valid after mid-block reset", int'(m_valid), 0);
    check(s_ready === 1'b0, "R11", "s_ready after mid-block reset", int'(s_ready), 0);
    repeat (11) @(negedge clk);
    rst_n = 1'b1;
    run_case(1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule